// File: doc/BRIEF.md
# Six-Phase Firing Pulse Generator

This block produces the six gate firing references for a three-phase, six-thyristor phase-angle controller. A fast master clock is divided by a fixed prescaler into angle steps. A step counter splits each line period into 72 steps of 5 degrees and restarts on every rising edge of the line zero-crossing reference. Six identical fire units compare the step count with the firing angle plus their own 60-degree offset. Each unit drives a pulse that lasts a fixed number of steps.

The downstream sequence scanner sees six registered pulse trains, which are phase-shifted copies of one firing angle. The firing angle is a step code from 0 to 35, giving 0 to 175 degrees. If the reference stops, the step counter holds at its last step. If the reference stays absent for more than two line periods, all outputs are muted until a new crossing arrives.

Top module: `firing_pulse_gen`

## Requirements
- R1: The step counter advances by one step every 16 master clocks (fixed prescale).
- R2: `zc_in` is synchronised through two flops. Its rising edge clears the step counter and the prescaler. When `zc_in` is first sampled high at clock edge E, the outputs for step 0 appear after edge E+3, and each step lasts 16 clocks.
- R3: When no crossing arrives by the end of step 71, the counter holds at 71, and the outputs keep the values they have for step 71.
- R4: Let a be the effective angle code. Output bit k of `fire_o` (k = 0..5) rises at the step (a + 12*k) mod 72.
- R5: Each pulse stays high for exactly 2 steps. A pulse that starts at step 71 continues into step 0 of the next period.
- R6: Angle codes above 35 act as code 35.
- R7: `fire_o` is all zero while `rst` is high. It stays all zero after reset until the first zero crossing.
- R8: If more than 144 steps (two line periods) pass without a crossing, `fire_o` is forced to all zero. Normal operation resumes at the next crossing.
- R9: `fire_o` is registered. Bit k carries phase offset 60*k degrees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Line zero-crossing square wave; a rising edge marks 0 degrees |
| angle_code | input | 6 | Firing angle in 5-degree steps, 0..35 |
| fire_o | output | 6 | Firing pulses; bit k is offset by 60*k degrees |

## Verification
The assertions check the following on every cycle:
- the prescale tick never appears on two adjacent clocks;
- the step count stays in range, returns to zero after a crossing, and holds at 71 when a tick arrives without a crossing;
- each fire unit rises on its target step;
- outputs are quiet while the reference is not locked;
- lock is lost only on a tick.

The bench scoreboard has to show the rest, because only a whole line period reveals it:
- the absolute timing from the crossing to each pulse;
- the 60-degree bit ordering;
- the two-step width and the wrap across a period;
- angle clamping;
- a late crossing;
- the exact step at which a missing reference mutes the outputs.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    REF_IDLE   = 2'd0,
    REF_LOCKED = 2'd1,
    REF_LOST   = 2'd2
  } ref_state_e;
endpackage

// File: rtl/fpg_zc_sync.sv
module fpg_zc_sync (
  input  logic clk,
  input  logic rst,
  input  logic zc_in,
  output logic zc_rise
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], zc_in};
  end

  assign zc_rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/fpg_prescaler.sv
module fpg_prescaler #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0] pcnt;

  assign tick = (pcnt == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (tick)      pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/fpg_step_counter.sv
module fpg_step_counter
  import fpg_pkg::*;
#(
  parameter int STEPS       = 72,
  parameter int MISS_CYCLES = 2,
  parameter int STEP_W      = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              zc_rise,
  output logic [STEP_W-1:0] step,
  output logic              ref_ok
);
  localparam int MISS_LIMIT = MISS_CYCLES * STEPS;
  localparam int MISS_W     = $clog2(MISS_LIMIT + 2);

  logic [MISS_W-1:0] since_zc;
  ref_state_e        state;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (zc_rise) begin
      step <= '0;
    end else if (tick && step != STEP_W'(STEPS - 1)) begin
      step <= step + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_zc <= '0;
      state    <= REF_IDLE;
    end else if (zc_rise) begin
      since_zc <= '0;
      state    <= REF_LOCKED;
    end else if (tick) begin
      if (since_zc != MISS_W'(MISS_LIMIT + 1)) since_zc <= since_zc + 1'b1;
      if (since_zc == MISS_W'(MISS_LIMIT) && state == REF_LOCKED) state <= REF_LOST;
    end
  end

  assign ref_ok = (state == REF_LOCKED);

  a_r2_range: assert property (@(posedge clk) disable iff (rst)
    step < STEP_W'(STEPS));
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    zc_rise |=> step == '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && !zc_rise && step == STEP_W'(STEPS - 1)) |=> step == STEP_W'(STEPS - 1));
  a_r8_lost_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_ok) |-> $past(tick));
endmodule

// File: rtl/fpg_fire_unit.sv
module fpg_fire_unit #(
  parameter int STEPS        = 72,
  parameter int STEP_W       = $clog2(STEPS),
  parameter int PHASE_OFFSET = 0,
  parameter int PULSE_STEPS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] angle,
  output logic              fire
);
  localparam int SW = STEP_W + 1;

  logic [SW-1:0] sum, tgt, pos, diff;
  logic          hit;

  always_comb begin
    sum  = {1'b0, angle} + SW'(PHASE_OFFSET);
    tgt  = (sum >= SW'(STEPS)) ? sum - SW'(STEPS) : sum;
    pos  = {1'b0, step};
    diff = (pos >= tgt) ? pos - tgt : pos + SW'(STEPS) - tgt;
    hit  = diff < SW'(PULSE_STEPS);
  end

  always_ff @(posedge clk) begin
    if (rst) fire <= 1'b0;
    else     fire <= enable & hit;
  end

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> !fire);
  a_r8_unlocked_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !fire);
  a_r4_fire_on_target: assert property (@(posedge clk) disable iff (rst)
    (enable && pos == tgt) |=> fire);
endmodule

// File: rtl/firing_pulse_gen.sv
module firing_pulse_gen #(
  parameter int PRESCALE    = 16,
  parameter int STEPS       = 72,
  parameter int PHASES      = 6,
  parameter int ANGLE_W     = 6,
  parameter int ANGLE_MAX   = 35,
  parameter int PULSE_STEPS = 2,
  parameter int MISS_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               zc_in,
  input  logic [ANGLE_W-1:0] angle_code,
  output logic [PHASES-1:0]  fire_o
);
  localparam int STEP_W    = $clog2(STEPS);
  localparam int PHASE_GAP = STEPS / PHASES;

  logic              zc_rise;
  logic              tick;
  logic [STEP_W-1:0] step;
  logic              ref_ok;
  logic [STEP_W-1:0] angle_sel;

  always_comb begin
    if (angle_code > ANGLE_W'(ANGLE_MAX)) angle_sel = STEP_W'(ANGLE_MAX);
    else                                  angle_sel = STEP_W'(angle_code);
  end

  fpg_zc_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .zc_in   (zc_in),
    .zc_rise (zc_rise)
  );

  fpg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (zc_rise),
    .tick    (tick)
  );

  fpg_step_counter #(
    .STEPS       (STEPS),
    .MISS_CYCLES (MISS_CYCLES),
    .STEP_W      (STEP_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .zc_rise (zc_rise),
    .step    (step),
    .ref_ok  (ref_ok)
  );

  for (genvar k = 0; k < PHASES; k++) begin : g_unit
    fpg_fire_unit #(
      .STEPS        (STEPS),
      .STEP_W       (STEP_W),
      .PHASE_OFFSET (k * PHASE_GAP),
      .PULSE_STEPS  (PULSE_STEPS)
    ) u_fire (
      .clk    (clk),
      .rst    (rst),
      .enable (ref_ok),
      .step   (step),
      .angle  (angle_sel),
      .fire   (fire_o[k])
    );
  end
endmodule

// File: tb/firing_pulse_gen_tb.sv
module firing_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       zc_in = 1'b0;
  logic [5:0] angle_code = '0;
  logic [5:0] fire_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int         when;
    logic [5:0] exp;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t item;

  firing_pulse_gen u_dut (
    .clk        (clk),
    .rst        (rst),
    .zc_in      (zc_in),
    .angle_code (angle_code),
    .fire_o     (fire_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  // Expected vector for step t, computed from R4, R5, R6, R9.
  function automatic logic [5:0] exp_vec(input int ang, input int t);
    logic [5:0] v;
    int a = (ang > 35) ? 35 : ang;
    for (int k = 0; k < 6; k++) begin
      int tgt = (a + 12 * k) % 72;
      int d = (t - tgt + 72) % 72;
      v[k] = (d < 2);
    end
    return v;
  endfunction

  // Monitor: compares each queued expectation at its sample cycle.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].when == cyc) begin
      item = q.pop_front();
      chk(item.req, fire_o, item.exp);
    end
  end

  // One line period. Step t is sampled mid-step at c + 12 + 16*t (R1, R2).
  // When extra > 0 the next crossing is late by that many steps (R3).
  task automatic line_cycle(input int ang, input int extra, input string req);
    int c;
    @(negedge clk);
    angle_code = ang[5:0];
    zc_in = 1'b1;
    c = cyc;
    for (int t = 0; t < 72 + extra; t++) begin
      exp_t e;
      e.when = c + 12 + 16 * t;
      e.exp  = exp_vec(ang, (t > 71) ? 71 : t);
      e.req  = req;
      q.push_back(e);
    end
    repeat (575) @(negedge clk);
    zc_in = 1'b0;
    repeat (1152 + 16 * extra - 576) @(negedge clk);
  endtask

  // Reference stops after one crossing: hold at 71, then muted after step 144 (R8).
  task automatic ref_loss(input int ang);
    int c;
    @(negedge clk);
    angle_code = ang[5:0];
    zc_in = 1'b1;
    c = cyc;
    for (int t = 0; t <= 150; t++) begin
      exp_t e;
      e.when = c + 12 + 16 * t;
      e.exp  = (t <= 144) ? exp_vec(ang, (t > 71) ? 71 : t) : 6'b0;
      e.req  = (t <= 144) ? "R3 saturate before loss" : "R8 muted after loss";
      q.push_back(e);
    end
    repeat (575) @(negedge clk);
    zc_in = 1'b0;
    repeat (16 * 160 - 576) @(negedge clk);
    chk("R8 still muted without crossing", fire_o, 6'b0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 reset", fire_o, 6'b0);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk("R7 no crossing yet", fire_o, 6'b0);

    line_cycle(0, 0, "R2 R4 angle 0 first lock");
    line_cycle(0, 0, "R1 R9 angle 0");
    line_cycle(7, 0, "R4 angle 7");
    line_cycle(35, 0, "R5 angle 35 wrap");
    line_cycle(35, 0, "R5 angle 35 wrap repeat");
    line_cycle(50, 0, "R6 code 50 clamped");
    line_cycle(63, 0, "R6 code 63 clamped");
    line_cycle(20, 4, "R3 late crossing angle 20");
    line_cycle(20, 0, "R4 angle 20");
    ref_loss(13);
    line_cycle(10, 0, "R8 relock angle 10");
    line_cycle(29, 0, "R4 angle 29");

    // Mid-run reset with zc_in low.
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 reset mid-run", fire_o, 6'b0);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    chk("R7 after reset before crossing", fire_o, 6'b0);

    line_cycle(1, 0, "R4 angle 1 after reset");
    line_cycle(24, 0, "R9 angle 24");

    repeat (20) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 scoreboard: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!done && cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule